// File: doc/BRIEF.md
# Serial configuration register slave

This block lets a host reach a bank of sixteen 8-bit configuration registers over a serial link. The link has three wires: an active-low select, a serial clock and a data line. It can also use a fourth wire. A transaction is a 16-bit frame, sent most significant bit first: a 4-bit command, a 4-bit register index, then an 8-bit value. The block is clocked by its own system clock. It resynchronises the three host signals to that clock and finds their edges, so the serial clock must be slow compared with the system clock.

A write command updates the addressed register when the frame ends. A read command latches the addressed register and returns it during the next select cycle, never in the same one. The route for the returned bits is chosen at run time by two bits of register 0x1. With both bits clear, the block is in 3-wire mode and drives the shared data line through an output-enable. With either bit set, the block is in 4-wire mode and uses one or both dedicated output pins.

A master-reset command clears the whole register bank. It holds the bank reset for as long as select stays deasserted. Register 0x0 supplies the power-enable outputs, and its bit 0 acts as a sleep override. The host paces every transfer, so the block has no flow control and no back-pressure.

Top module: `serial_cfg_slave`

## Requirements
- R1: After reset, all sixteen registers read 0. `dio_oe`, `dout_a`, `dout_b`, `bank_rst` and `pwr_en` are all 0.
- R2: A frame with command 0x1 writes its data byte into the register given by its address field. The frame bits are sampled on rising serial-clock edges while `cs_n` is low. Bits 15..12 are the command, bits 11..8 the address and bits 7..0 the data, most significant bit first. The write takes effect after `cs_n` returns high.
- R3: A frame with fewer than 16 serial-clock rising edges changes no register. So does a frame whose command is neither 0x1, 0x2 nor 0x3 (for example 0x0 or 0xF).
- R4: A frame with more than 16 rising edges is decoded from the last 16 bits received.
- R5: After a frame with command 0x2, the next select cycle returns the addressed register most significant bit first. Bit 7 is valid once `cs_n` is low, and each following bit appears after a falling serial-clock edge. The host may give 8 or 16 clocks, and bits after the eighth read as 0.
- R6: When bits 1..0 of register 0x1 are both 0, the block drives `dio_oe` high throughout the response cycle with the data on `dio_out`, and keeps `dout_a` and `dout_b` at 0.
- R7: When register 0x1 bit 0 is set, response data appears on `dout_a`. When bit 1 is set, it appears on `dout_b`. When both are set, it appears on both pins. In all three cases `dio_oe` stays 0.
- R8: A frame with command 0x3 clears every register. `bank_rst` is then high from the end of that frame until `cs_n` next goes low.
- R9: The serial-clock edges and data-line values of a response cycle are never decoded as a command.
- R10: When register 0x0 bit 0 is 0, `pwr_en` equals register 0x0 bits 7..1. When that bit is 1, `pwr_en` is 0.
- R11: A read command produces exactly one response cycle. In the select cycle after the response, no output is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host select, active low |
| sclk | input | 1 | Host serial clock |
| dio_in | input | 1 | Data line as seen at the pad input |
| dio_out | output | 1 | Data line drive value in 3-wire mode |
| dio_oe | output | 1 | Data line output enable |
| dout_a | output | 1 | Dedicated read-data pin A |
| dout_b | output | 1 | Dedicated read-data pin B |
| bank_rst | output | 1 | Master reset held on the register bank |
| pwr_en | output | 7 | Power enables after the sleep override |
| cfg_regs | output | 128 | All registers, register n at bits 8n+7..8n |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, a 4-bit command, a 4-bit address, an 8-bit data field, and the routing bits at register 0x1, bits 1..0. These defaults allow a serial half-period of six system clocks. That gives room to sample each response bit just before the host's rising edge, in both the 8-clock and the 16-clock form. They also allow every routing combination and the sleep override to be exercised through ordinary frames. Short, long and unknown-command frames, writes attempted inside a response cycle, and the master-reset hold are all judged by reading registers back over the serial link.

// File: rtl/sif_pkg.sv
`timescale 1ns/1ps
package sif_pkg;
  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] OP_WRITE = 4'h1;
  localparam logic [CMD_W-1:0] OP_READ  = 4'h2;
  localparam logic [CMD_W-1:0] OP_MRST  = 4'h3;

  localparam int NUM_DOUT = 2;
endpackage

// File: rtl/sif_sync.sv
`timescale 1ns/1ps
module sif_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/sif_frame.sv
`timescale 1ns/1ps
module sif_frame #(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              din_s,
  input  logic              rd_pending,
  output logic              frame_start,
  output logic              commit,
  output logic              resp,
  output logic              sck_fall,
  output logic [CMD_W-1:0]  cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  localparam int FRAME_BITS = CMD_W + ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic                  cs_q;
  logic                  sck_q;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      cnt;
  logic                  cs_rise;
  logic                  sck_rise;

  assign frame_start = cs_q & ~cs_n_s;
  assign cs_rise     = ~cs_q & cs_n_s;
  assign sck_rise    = ~sck_q & sck_s & ~cs_n_s;
  assign sck_fall    = sck_q & ~sck_s & ~cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_n_s;
      sck_q <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      resp  <= 1'b0;
    end else if (frame_start) begin
      cnt  <= '0;
      resp <= rd_pending;
    end else if (cs_rise) begin
      resp <= 1'b0;
    end else if (sck_rise) begin
      shreg <= {shreg[FRAME_BITS-2:0], din_s};
      if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
    end
  end

  assign commit = cs_rise & ~resp & (cnt == CNT_FULL);
  assign cmd    = shreg[FRAME_BITS-1 -: CMD_W];
  assign addr   = shreg[DATA_W +: ADDR_W];
  assign wdata  = shreg[DATA_W-1:0];

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_FULL && !frame_start) |=> (cnt == CNT_FULL)); // R4
endmodule

// File: rtl/sif_regbank.sv
`timescale 1ns/1ps
module sif_regbank #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [ADDR_W-1:0]             raddr,
  output logic [DATA_W-1:0]             rdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0] flat
);
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   regs <= '0;
    else if (clr) regs <= '0;
    else if (we)  regs[waddr] <= wdata;
  end

  assign rdata = regs[raddr];
  assign flat  = regs;
endmodule

// File: rtl/sif_txout.sv
`timescale 1ns/1ps
module sif_txout
  import sif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [DATA_W-1:0]   ld_byte,
  input  logic [NUM_DOUT-1:0] ld_route,
  input  logic                resp,
  input  logic                sck_fall,
  output logic                dio_out,
  output logic                dio_oe,
  output logic [NUM_DOUT-1:0] dout
);
  logic [DATA_W-1:0]   tx;
  logic [NUM_DOUT-1:0] route;
  logic                cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx    <= '0;
      route <= '0;
    end else if (load) begin
      tx    <= ld_byte;
      route <= ld_route;
    end else if (resp && sck_fall) begin
      tx <= {tx[DATA_W-2:0], 1'b0};
    end
  end

  assign cur_bit = tx[DATA_W-1];
  assign dio_oe  = resp & (route == '0);
  assign dio_out = dio_oe & cur_bit;

  for (genvar p = 0; p < NUM_DOUT; p++) begin : g_dout
    assign dout[p] = resp & route[p] & cur_bit;
  end

  AST_SINGLE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    dio_oe |-> (dout == '0)); // R7
endmodule

// File: rtl/serial_cfg_slave.sv
`timescale 1ns/1ps
module serial_cfg_slave
  import sif_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ROUTE_ADDR  = 1,
  parameter int ROUTE_LSB   = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          sclk,
  input  logic                          dio_in,
  output logic                          dio_out,
  output logic                          dio_oe,
  output logic                          dout_a,
  output logic                          dout_b,
  output logic                          bank_rst,
  output logic [DATA_W-2:0]             pwr_en,
  output logic [(1<<ADDR_W)*DATA_W-1:0] cfg_regs
);
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int FLAT_W   = NUM_REGS * DATA_W;

  logic [2:0]          sync_q;
  logic                cs_n_s, sck_s, din_s;
  logic                frame_start, commit, resp, sck_fall;
  logic [CMD_W-1:0]    cmd;
  logic [ADDR_W-1:0]   addr;
  logic [DATA_W-1:0]   wdata, rdata;
  logic [FLAT_W-1:0]   cfg_flat;
  logic                rd_pending;
  logic                mrst;
  logic                is_write, is_read, is_mrst;
  logic [NUM_DOUT-1:0] route_bits;
  logic [NUM_DOUT-1:0] dout;
  logic [DATA_W-1:0]   reg0;

  sif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, dio_in}), .q(sync_q)
  );
  assign {cs_n_s, sck_s, din_s} = sync_q;

  sif_frame #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s), .din_s(din_s),
    .rd_pending(rd_pending), .frame_start(frame_start), .commit(commit),
    .resp(resp), .sck_fall(sck_fall), .cmd(cmd), .addr(addr), .wdata(wdata)
  );

  assign is_write = commit && (cmd == OP_WRITE);
  assign is_read  = commit && (cmd == OP_READ);
  assign is_mrst  = commit && (cmd == OP_MRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pending <= 1'b0;
      mrst       <= 1'b0;
    end else if (frame_start) begin
      rd_pending <= 1'b0;
      mrst       <= 1'b0;
    end else begin
      if (is_read) rd_pending <= 1'b1;
      if (is_mrst) mrst       <= 1'b1;
    end
  end

  sif_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(mrst), .we(is_write), .waddr(addr),
    .wdata(wdata), .raddr(addr), .rdata(rdata), .flat(cfg_flat)
  );

  assign route_bits = cfg_flat[ROUTE_ADDR*DATA_W + ROUTE_LSB +: NUM_DOUT];

  sif_txout #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(is_read), .ld_byte(rdata),
    .ld_route(route_bits), .resp(resp), .sck_fall(sck_fall),
    .dio_out(dio_out), .dio_oe(dio_oe), .dout(dout)
  );

  assign dout_a   = dout[0];
  assign dout_b   = dout[1];
  assign bank_rst = mrst;
  assign cfg_regs = cfg_flat;

  assign reg0   = cfg_flat[DATA_W-1:0];
  assign pwr_en = reg0[0] ? '0 : reg0[DATA_W-1:1];

  AST_RESP_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    resp |-> !rd_pending); // R11
  AST_MRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |-> (!dio_oe && dout == '0)); // R8
  AST_BANK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (cfg_flat == '0)); // R8
  AST_NO_WRITE_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp |=> $stable(cfg_flat) || $past(mrst)); // R9
endmodule

// File: tb/serial_cfg_slave_bench.sv
`timescale 1ns/1ps
module serial_cfg_slave_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic dio_in = 1'b0;
  logic dio_out, dio_oe, dout_a, dout_b, bank_rst;
  logic [6:0]   pwr_en;
  logic [127:0] cfg_regs;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  serial_cfg_slave u_serial_cfg_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dio_in(dio_in),
    .dio_out(dio_out), .dio_oe(dio_oe), .dout_a(dout_a), .dout_b(dout_b),
    .bank_rst(bank_rst), .pwr_en(pwr_en), .cfg_regs(cfg_regs)
  );

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    cs_n = 1'b0;
    wt(H);
    for (int i = n - 1; i >= 0; i--) begin
      dio_in = v[i];
      wt(H);
      sclk = 1'b1;
      wt(H);
      sclk = 1'b0;
    end
    dio_in = 1'b0;
    wt(H);
    cs_n = 1'b1;
    wt(4 * H);
  endtask

  task automatic frame(logic [3:0] c, logic [3:0] a, logic [7:0] d);
    send_bits({16'h0, c, a, d}, 16);
  endtask

  task automatic do_read(logic [3:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    frame(4'h2, a, 8'h00);
  endtask

  // sel: 0 shared line, 1 pin A, 2 pin B, 3 both pins
  task automatic rx(int nclk, logic [15:0] pat, int sel, bit drive, string tag);
    logic [7:0] got;
    logic       b;
    logic       bad;
    got = '0;
    bad = 1'b0;
    cs_n = 1'b0;
    wt(H);
    for (int i = 0; i < nclk; i++) begin
      dio_in = pat[15-i];
      wt(H);
      b = 1'b0;
      if (!drive) begin
        bad |= dio_oe | dout_a | dout_b;
      end else begin
        case (sel)
          0: begin bad |= (dio_oe !== 1'b1) | dout_a | dout_b; b = dio_out; end
          1: begin bad |= dio_oe | dout_b; b = dout_a; end
          2: begin bad |= dio_oe | dout_a; b = dout_b; end
          default: begin bad |= dio_oe | (dout_a !== dout_b); b = dout_a; end
        endcase
        if (i < 8) got = {got[6:0], b};
        else       bad |= b;
      end
      sclk = 1'b1;
      wt(H);
      sclk = 1'b0;
    end
    dio_in = 1'b0;
    wt(H);
    cs_n = 1'b1;
    wt(4 * H);
    check_eq({tag, " output path"}, {31'h0, bad}, 32'h0);
    if (drive) act_q.push_back(got);
  endtask

  function automatic logic [7:0] reg_of(int n);
    return cfg_regs[n*8 +: 8];
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (act_q.size() > 0 && exp_q.size() > 0) begin
        check_eq({tag_q.pop_front(), " read data"}, {24'h0, act_q.pop_front()},
                 {24'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1 reset state
    check_eq("R1 dio_oe", {31'h0, dio_oe}, 0);
    check_eq("R1 dout pins", {30'h0, dout_a, dout_b}, 0);
    check_eq("R1 bank_rst", {31'h0, bank_rst}, 0);
    check_eq("R1 pwr_en", {25'h0, pwr_en}, 0);
    check_eq("R1 registers", {31'h0, |cfg_regs}, 0);

    // R2 write and R5/R6 read with 16 clocks on the shared line
    frame(4'h1, 4'h5, 8'hA5);
    check_eq("R2 write reg5", {24'h0, reg_of(5)}, 32'hA5);
    do_read(4'h5, 8'hA5, "R5 16clk");
    rx(16, 16'h0, 0, 1, "R6 3-wire");

    // R5 read with only 8 clocks
    frame(4'h1, 4'h7, 8'h3C);
    do_read(4'h7, 8'h3C, "R5 8clk");
    rx(8, 16'h0, 0, 1, "R5 8clk");

    // R3 short frame and unknown commands
    send_bits(32'h15FF >> 1, 15);
    check_eq("R3 short frame", {24'h0, reg_of(5)}, 32'hA5);
    frame(4'hF, 4'h5, 8'h11);
    check_eq("R3 cmd F", {24'h0, reg_of(5)}, 32'hA5);
    frame(4'h0, 4'h5, 8'h11);
    check_eq("R3 cmd 0", {24'h0, reg_of(5)}, 32'hA5);

    // R4 long frame uses last 16 bits
    send_bits({12'h0, 4'hA, 16'h1577}, 20);
    check_eq("R4 long frame", {24'h0, reg_of(5)}, 32'h77);

    // R9 write pattern during response cycle is ignored
    do_read(4'h7, 8'h3C, "R9");
    rx(16, 16'h1700, 0, 1, "R9");
    check_eq("R9 reg7 kept", {24'h0, reg_of(7)}, 32'h3C);

    // R11 only one response cycle
    do_read(4'h5, 8'h77, "R11");
    rx(16, 16'h0, 0, 1, "R11 response");
    rx(16, 16'h0, 0, 0, "R11 following cycle");

    // R10 sleep override
    frame(4'h1, 4'h0, 8'hF0);
    check_eq("R10 enables", {25'h0, pwr_en}, 32'h78);
    frame(4'h1, 4'h0, 8'hF1);
    check_eq("R10 sleep", {25'h0, pwr_en}, 32'h0);

    // R7 4-wire routing
    frame(4'h1, 4'h1, 8'h01);
    do_read(4'h7, 8'h3C, "R7 pin A");
    rx(16, 16'h0, 1, 1, "R7 pin A");
    frame(4'h1, 4'h1, 8'h02);
    do_read(4'h5, 8'h77, "R7 pin B");
    rx(16, 16'h0, 2, 1, "R7 pin B");
    frame(4'h1, 4'h1, 8'h03);
    do_read(4'h1, 8'h03, "R7 both");
    rx(8, 16'h0, 3, 1, "R7 both");

    // R8 master reset
    frame(4'h3, 4'h0, 8'h00);
    check_eq("R8 bank_rst high", {31'h0, bank_rst}, 1);
    check_eq("R8 bank cleared", {31'h0, |cfg_regs}, 0);
    wt(20);
    check_eq("R8 bank_rst held", {31'h0, bank_rst}, 1);
    cs_n = 1'b0;
    wt(H);
    check_eq("R8 bank_rst released", {31'h0, bank_rst}, 0);
    cs_n = 1'b1;
    wt(4 * H);
    do_read(4'h5, 8'h00, "R8 reg5 cleared");
    rx(16, 16'h0, 0, 1, "R8 3-wire restored");

    wt(20);
    check_eq("scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule